// File: doc/BRIEF.md
# Configuration Startup Sequencer

This controller walks a reprogrammable logic device from a configuration request to normal operation. Pulling the active-low program request low in any state throws away whatever progress was made. It also re-blocks the global controls and starts a memory-clear phase of `CLEAR_CYCLES` clocks, counted from the last clock edge that saw the request low. When the clear ends, `init_done` goes high and the block accepts a byte stream.

The stream uses a valid/ready interface. `s_ready` is high only while the load phase is open. A byte moves only on a clock edge where `s_valid` and `s_ready` are both high. The source may hold `s_valid` low for any number of cycles, and a byte it offers outside the load phase is dropped without effect. The first accepted byte is the option byte. `PAYLOAD_BYTES` more bytes complete the stream.

Once the stream is complete, the block pulses the global set/reset for one cycle. It then performs three startup steps on three consecutive cycles: raising `done`, releasing the output tri-state hold and releasing the write freeze. Two option bits choose the order of these steps.

Top module: `cfg_startup_seq`

## Requirements
- R1: After reset, `init_done`, `done`, `gsr` and `s_ready` are low and `out_hiz` and `write_freeze` are high. Nothing changes until a program request arrives.
- R2: When `prog_req_n` is sampled low in any state, the following cycle shows `init_done`, `done`, `gsr` and `s_ready` low and `out_hiz` and `write_freeze` high. The clear phase and the byte count both start again.
- R3: `init_done` rises exactly `CLEAR_CYCLES` clock edges after the last edge that sampled `prog_req_n` low. `done` is never high while `init_done` is low.
- R4: `s_ready` is high exactly while the load phase is open. A byte offered in any other phase is ignored.
- R5: The edge that accepts the final byte, which is byte number `PAYLOAD_BYTES+1` counting the option byte, makes `gsr` high for exactly one cycle. `s_ready` is low in that same cycle.
- R6: When option bits 1:0 are 00, `done` rises in the cycle after `gsr`. `out_hiz` falls one cycle later, and `write_freeze` falls one cycle after that.
- R7: Option bit 0 (bit 0 of the first byte) swaps the two releases. `done` still comes first, then `write_freeze` falls, then `out_hiz` falls.
- R8: Option bit 1 moves `done` to the last of the three steps. The two releases come first, in the order chosen by bit 0. Option bits 7:2 have no effect.
- R9: A cycle without a handshake leaves the byte count unchanged, so idle gaps in `s_valid` only lengthen the load phase.
- R10: After the three steps, the outputs hold their released values and `s_ready` stays low until the next program request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req_n | input | 1 | Active-low program request; restarts the sequence |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DATA_W | Stream byte; the first byte carries the option bits |
| s_ready | output | 1 | Stream ready; high only during the load phase |
| init_done | output | 1 | High once the clear phase has finished |
| gsr | output | 1 | One-cycle global set/reset pulse |
| done | output | 1 | Configuration complete |
| out_hiz | output | 1 | High while device outputs are held tri-stated |
| write_freeze | output | 1 | High while storage writes are blocked |

## Verification
Every result has a fixed latency in edges:
- a program request acts on the very next cycle;
- `init_done` follows `CLEAR_CYCLES` edges later;
- `gsr` appears in the cycle after the accepting edge of the final byte;
- the three startup steps land one, two and three cycles after `gsr` begins, in the order set by the option byte.

The bench drives inputs just after the rising edge. A behavioural model advances on the same rising edges from the same sampled inputs. Every output is compared with the model at the falling edge, so each comparison lands in the cycle in which the result is due. The stimulus covers gaps in `s_valid`, bytes offered outside the load phase, all four option orders, and restarts during the clear, load and release phases.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_LOAD,
    ST_GSR,
    ST_START,
    ST_RUN
  } seq_state_e;

  // startup events, one flag each
  localparam int EV_DONE = 0;
  localparam int EV_OUT  = 1;
  localparam int EV_WR   = 2;
  localparam int NUM_EV  = 3;

  // option byte bit positions
  localparam int OPT_SWAP_BIT      = 0;
  localparam int OPT_DONE_LAST_BIT = 1;
  localparam int OPT_W             = 2;

  // step (0..2) after the set/reset pulse at which an event fires
  function automatic logic [1:0] ev_slot(input logic [OPT_W-1:0] ord, input int ev);
    logic [1:0] base;
    base = ord[OPT_DONE_LAST_BIT] ? 2'd0 : 2'd1;
    case (ev)
      EV_DONE: return ord[OPT_DONE_LAST_BIT] ? 2'd2 : 2'd0;
      EV_OUT:  return base + {1'b0, ord[OPT_SWAP_BIT]};
      default: return base + {1'b0, ~ord[OPT_SWAP_BIT]};
    endcase
  endfunction

endpackage

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
  parameter int CLEAR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= expired ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int PAYLOAD_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic [OPT_W-1:0]  ord,
  output logic              last_beat
);
  localparam int TOTAL = PAYLOAD_BYTES + 1;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [OPT_W-1:0] ord_q;
  logic             take;

  assign s_ready   = active;
  assign take      = s_valid && active && !restart;
  assign last_beat = take && (cnt_q == LAST);
  assign ord       = ord_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ord_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      ord_q <= '0;
    end else if (take) begin
      cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
      if (cnt_q == '0) ord_q <= s_data[OPT_W-1:0];
    end
  end
endmodule

// File: rtl/cfg_release_seq.sv
module cfg_release_seq
  import cfg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              kick,
  input  logic [OPT_W-1:0]  ord,
  output logic [NUM_EV-1:0] released,
  output logic              last_step
);
  logic [1:0] step_q;
  logic       busy_q;
  logic [1:0] cur_step;
  logic       fire;

  assign cur_step  = kick ? 2'd0 : step_q;
  assign fire      = (kick || busy_q) && !restart;
  assign last_step = busy_q && (step_q == 2'd2) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      busy_q <= 1'b0;
    end else if (restart) begin
      step_q <= '0;
      busy_q <= 1'b0;
    end else if (kick) begin
      step_q <= 2'd1;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (step_q == 2'd2) begin
        step_q <= '0;
        busy_q <= 1'b0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    logic ev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_q <= 1'b0;
      end else if (restart) begin
        ev_q <= 1'b0;
      end else if (fire && (ev_slot(ord, g) == cur_step)) begin
        ev_q <= 1'b1;
      end
    end
    assign released[g] = ev_q;
  end
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLEAR_CYCLES  = 16,
  parameter int PAYLOAD_BYTES = 8,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              init_done,
  output logic              gsr,
  output logic              done,
  output logic              out_hiz,
  output logic              write_freeze
);
  seq_state_e        state_q, state_d;
  logic              restart;
  logic              clr_expired;
  logic              last_beat;
  logic              last_step;
  logic [OPT_W-1:0]  ord;
  logic [NUM_EV-1:0] released;

  assign restart = !prog_req_n;

  cfg_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_clear (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (state_q == ST_CLEAR),
    .expired (clr_expired)
  );

  cfg_stream_loader #(.DATA_W(DATA_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .active    (state_q == ST_LOAD),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .ord       (ord),
    .last_beat (last_beat)
  );

  cfg_release_seq u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .kick      (state_q == ST_GSR),
    .ord       (ord),
    .released  (released),
    .last_step (last_step)
  );

  always_comb begin
    state_d = state_q;
    if (restart) begin
      state_d = ST_CLEAR;
    end else begin
      case (state_q)
        ST_CLEAR: if (clr_expired) state_d = ST_LOAD;
        ST_LOAD:  if (last_beat)   state_d = ST_GSR;
        ST_GSR:                    state_d = ST_START;
        ST_START: if (last_step)   state_d = ST_RUN;
        default:                   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign init_done    = (state_q != ST_IDLE) && (state_q != ST_CLEAR);
  assign gsr          = (state_q == ST_GSR);
  assign done         = released[EV_DONE];
  assign out_hiz      = !released[EV_OUT];
  assign write_freeze = !released[EV_WR];
endmodule

// File: rtl/cfg_startup_seq_chk.sv
module cfg_startup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_req_n,
  input logic s_ready,
  input logic init_done,
  input logic gsr,
  input logic done,
  input logic out_hiz,
  input logic write_freeze
);
  assert_restart_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req_n |=> (!init_done && !done && !gsr && !s_ready && out_hiz && write_freeze));

  assert_done_needs_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> init_done);

  assert_ready_only_loading_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (init_done && !done && !gsr));

  assert_gsr_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |=> !gsr);

  assert_gsr_before_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |-> (!done && out_hiz && write_freeze && !s_ready));

  assert_one_step_per_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({$rose(done), $fell(out_hiz), $fell(write_freeze)}) <= 1);

  assert_released_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_n && done && !out_hiz && !write_freeze)
      |=> (done && !out_hiz && !write_freeze && !s_ready));
endmodule

bind cfg_startup_seq cfg_startup_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .prog_req_n   (prog_req_n),
  .s_ready      (s_ready),
  .init_done    (init_done),
  .gsr          (gsr),
  .done         (done),
  .out_hiz      (out_hiz),
  .write_freeze (write_freeze)
);

// File: tb/cfg_startup_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_startup_seq_tb_top;
  localparam int CLR = 6;
  localparam int PAY = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_req_n = 1'b1;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, init_done, gsr, done, out_hiz, write_freeze;

  always #2.5 clk = ~clk;

  cfg_startup_seq #(.CLEAR_CYCLES(CLR), .PAYLOAD_BYTES(PAY), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_req_n(prog_req_n),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .init_done(init_done), .gsr(gsr), .done(done),
    .out_hiz(out_hiz), .write_freeze(write_freeze)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // behavioural reference: 0 idle, 1 clear, 2 load, 3 set/reset, 4 startup/run
  int   m_ph = 0;
  int   m_cnt = 0;
  int   m_nb = 0;
  int   m_t = 0;
  logic [1:0] m_opt = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_nb = 0; m_t = 0; m_opt = 2'b00;
    end else if (!prog_req_n) begin
      m_ph = 1; m_cnt = 0; m_nb = 0; m_t = 0; m_opt = 2'b00;
    end else begin
      case (m_ph)
        1: begin
          m_cnt++;
          if (m_cnt == CLR) begin m_ph = 2; m_nb = 0; end
        end
        2: if (s_valid) begin
          if (m_nb == 0) m_opt = s_data[1:0];
          m_nb++;
          if (m_nb == PAY + 1) m_ph = 3;
        end
        3: begin m_ph = 4; m_t = 1; end
        4: if (m_t < 8) m_t++;
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int p_done, p_base, p_out, p_wr;
      p_done = m_opt[1] ? 3 : 1;
      p_base = m_opt[1] ? 1 : 2;
      p_out  = p_base + (m_opt[0] ? 1 : 0);
      p_wr   = p_base + (m_opt[0] ? 0 : 1);
      chk(cur_req, "init_done",    init_done,    m_ph >= 2);
      chk(cur_req, "s_ready",      s_ready,      m_ph == 2);
      chk(cur_req, "gsr",          gsr,          m_ph == 3);
      chk(cur_req, "done",         done,         (m_ph == 4) && (m_t >= p_done));
      chk(cur_req, "out_hiz",      out_hiz,      !((m_ph == 4) && (m_t >= p_out)));
      chk(cur_req, "write_freeze", write_freeze, !((m_ph == 4) && (m_t >= p_wr)));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic program_pulse(input int len);
    prog_req_n = 1'b0;
    step(len);
    prog_req_n = 1'b1;
  endtask

  task automatic send(input logic [DW-1:0] v);
    logic rdy;
    s_valid = 1'b1;
    s_data  = v;
    forever begin
      @(negedge clk);
      rdy = s_ready;
      @(posedge clk); #1;
      if (rdy) break;
    end
    s_valid = 1'b0;
    s_data  = '0;
  endtask

  task automatic load(input logic [DW-1:0] opt, input int gap);
    send(opt);
    for (int i = 0; i < PAY; i++) begin
      send(DW'(i * 3 + 5));
      if (gap > 0) step(gap);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    cur_req = "R1";
    step(4);
    // R4: bytes offered before any request are dropped
    cur_req = "R4";
    s_valid = 1'b1; s_data = 8'hFF;
    step(3);
    s_valid = 1'b0; s_data = '0;
    // R3: clear timing, R9: gaps in valid, R6: default order
    cur_req = "R2"; program_pulse(1);
    cur_req = "R3"; step(CLR);
    cur_req = "R9"; load(8'h00, 2);
    cur_req = "R6"; step(6);
    // R10: stream ignored once running
    cur_req = "R10";
    s_valid = 1'b1; s_data = 8'h03;
    step(4);
    s_valid = 1'b0; s_data = '0;
    // R7: swapped releases, request held low several cycles
    cur_req = "R2"; program_pulse(3);
    cur_req = "R7"; load(8'h01, 0); step(6);
    // R2: restart in the middle of loading, then R8 order
    cur_req = "R2"; program_pulse(1);
    send(8'h02); send(8'h11);
    program_pulse(1);
    cur_req = "R8"; load(8'hFE, 1); step(6);
    // R2: restart during the release steps, then order 11
    cur_req = "R2"; program_pulse(1);
    load(8'h03, 0); step(1);
    program_pulse(1);
    cur_req = "R8"; load(8'h03, 0); step(6);
    finish_run();
  end
endmodule